// File: doc/BRIEF.md
# NAND Target Command and Address Sequencer

This block is the device-side front end of a NAND-style flash target. On every cycle where the write strobe is high and the chip is selected, it samples two latch qualifiers and an 8-bit bus. It then sorts the byte into one of three kinds: an operation code, an address byte or a data-input byte. It tracks which operation is in progress and how many address bytes that operation still needs. It assembles the column and row address, writes program data into an on-chip page buffer, and keeps a sticky pass/fail flag.

When the host misuses the protocol, the block recovers without further help. A command that arrives in the wrong phase aborts the pending operation, sets the flag to fail, and is then handled as if the sequencer were ready. A stray address byte or data byte also marks a failure and returns the sequencer to ready. Data written past the end of the page buffer is dropped quietly. The flash array, program and erase timing, and error correction sit outside this block. Downstream logic uses the one-cycle event outputs, the phase output and the assembled address to start the real array work.

Top module: `nand_cmd_seq`

## Requirements
- R1: A write strobe with `chip_en` low changes no output and no state.
- R2: A write strobe with `cmd_latch` and `addr_latch` both high is ignored and changes no state.
- R3: Command 0xFF is accepted in every phase. One cycle later `seq_state` is 0 (ready) and `fail_flag` is 0. No other event clears `fail_flag`.
- R4: A command other than the awaited confirm can arrive while `seq_state` is 1 (address), 2 (data-in) or 3 (erase-confirm wait). It sets `fail_flag` and abandons the operation, and the byte is then processed exactly as it would be in ready.
- R5: In ready, a byte outside the table {0x00 read, 0x80 program, 0x60 erase, 0x70 status, 0x90 ID, 0xFF reset} is ignored. The confirm codes 0x10 and 0xD0 are also ignored in ready.
- R6: Read (0x00) and program (0x80) take `PG_BYTES` address bytes (default 2). Erase (0x60) takes `SEC_BYTES` (default 3). ID (0x90) takes exactly 1. Status (0x70) takes none and leaves the sequencer in ready.
- R7: An address strobe while `seq_state` is not 1 sets `fail_flag` and returns to ready.
- R8: Accepting the last address byte pulses `addr_done` for one cycle and moves to the next phase. Read and ID go to ready, program goes to data-in (2) and erase goes to erase-confirm wait (3). Code 0x10 in data-in and code 0xD0 in erase-confirm wait return to ready with no change to the flag.
- R9: For page operations, the first `COL_BYTES` address bytes (default 1) fill `col_addr` least significant byte first, and the remaining bytes fill `row_addr` in the same order. Erase bytes all fill `row_addr`, and the ID byte is not stored. Both registers clear when an operation starts.
- R10: A data strobe while `seq_state` is not 2 sets `fail_flag` and returns to ready.
- R11: In data-in, each data byte is stored at buffer index `din_count`, and `din_count` then grows by 1, or by 2 when `WIDE_BUS` is 1. Once `din_count` reaches `PAGE_BYTES`, further data bytes are dropped with no change to any output. `din_count` clears when a program starts.
- R12: `op_start` pulses for one cycle when read, program, erase, status or ID is accepted.
- R13: `rd_data` returns the buffer byte at `rd_addr` one cycle after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe, one byte per cycle |
| chip_en | input | 1 | Chip select, active high |
| cmd_latch | input | 1 | Byte is an operation code |
| addr_latch | input | 1 | Byte is an address byte |
| wr_byte | input | 8 | Write bus |
| rd_addr | input | AW | Page buffer read index |
| rd_data | output | 8 | Registered page buffer byte |
| seq_state | output | 2 | 0 ready, 1 address, 2 data-in, 3 erase-confirm wait |
| fail_flag | output | 1 | Status bit 0: 1 = last operation failed |
| op_start | output | 1 | One-cycle pulse when an operation is accepted |
| addr_done | output | 1 | One-cycle pulse on the final address byte |
| col_addr | output | 8*COL_BYTES | Assembled column address |
| row_addr | output | 8*ROW_BYTES | Assembled row address |
| din_count | output | CW | Data-in byte count |

## Verification
The main stimulus is a set of well-formed operations: a read with two address bytes, an ID with one byte, a status with none, and a three-byte erase followed by its confirm. These show that each operation takes its own address count and routes each byte to the right register. Program streams are checked twice: a short stream with readback proves where bytes land, and a 530-byte stream separates the drop-at-full rule from the fail-on-misuse rule. Misuse patterns then cover a command during the address phase, an unknown command during the address phase, stray address and data bytes, deselected or doubly-qualified strobes, and a reset in mid-program, each with its expected effect on the flag. A second instance with the wide bus enabled runs the same stream and shows the step of two.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    SQ_READY = 2'd0,
    SQ_ADDR  = 2'd1,
    SQ_DATA  = 2'd2,
    SQ_ECONF = 2'd3
  } sq_state_t;

  typedef enum logic [1:0] {
    AK_NONE = 2'd0,
    AK_PAGE = 2'd1,
    AK_SECT = 2'd2,
    AK_ZERO = 2'd3
  } akind_t;

  localparam logic [7:0] OPC_RESET = 8'hFF;
  localparam logic [7:0] OPC_READ  = 8'h00;
  localparam logic [7:0] OPC_PROG  = 8'h80;
  localparam logic [7:0] OPC_PCONF = 8'h10;
  localparam logic [7:0] OPC_ERASE = 8'h60;
  localparam logic [7:0] OPC_ECONF = 8'hD0;
  localparam logic [7:0] OPC_STAT  = 8'h70;
  localparam logic [7:0] OPC_ID    = 8'h90;

  typedef struct packed {
    logic      starts;    // opens a new operation
    akind_t    kind;      // address format it needs
    sq_state_t after;     // phase entered when address completes
    logic      clr_data;  // clears the data-in count
  } op_info_t;

endpackage

// File: rtl/nand_op_decode.sv
module nand_op_decode
  import nand_seq_pkg::*;
(
  input  logic [7:0] opc,
  output op_info_t   info,
  output logic       is_reset,
  output logic       is_pconf,
  output logic       is_econf
);

  always_comb begin
    info     = '{starts: 1'b0, kind: AK_NONE, after: SQ_READY, clr_data: 1'b0};
    is_reset = 1'b0;
    is_pconf = 1'b0;
    is_econf = 1'b0;
    case (opc)
      OPC_RESET: is_reset = 1'b1;
      OPC_PCONF: is_pconf = 1'b1;
      OPC_ECONF: is_econf = 1'b1;
      OPC_READ:  info = '{starts: 1'b1, kind: AK_PAGE, after: SQ_READY, clr_data: 1'b0};
      OPC_PROG:  info = '{starts: 1'b1, kind: AK_PAGE, after: SQ_DATA,  clr_data: 1'b1};
      OPC_ERASE: info = '{starts: 1'b1, kind: AK_SECT, after: SQ_ECONF, clr_data: 1'b0};
      OPC_ID:    info = '{starts: 1'b1, kind: AK_ZERO, after: SQ_READY, clr_data: 1'b0};
      OPC_STAT:  info = '{starts: 1'b1, kind: AK_NONE, after: SQ_READY, clr_data: 1'b0};
      default:   info = '{starts: 1'b0, kind: AK_NONE, after: SQ_READY, clr_data: 1'b0};
    endcase
  end

endmodule

// File: rtl/nand_addr_collect.sv
module nand_addr_collect
  import nand_seq_pkg::*;
#(
  parameter int PG_BYTES  = 2,
  parameter int SEC_BYTES = 3,
  parameter int COL_BYTES = 1,
  parameter int ROW_BYTES = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  akind_t                 kind_in,
  input  logic                   take,
  input  logic [7:0]             byte_in,
  output logic                   last,
  output logic [8*COL_BYTES-1:0] col,
  output logic [8*ROW_BYTES-1:0] row
);

  localparam int MAXB = (PG_BYTES > SEC_BYTES) ? PG_BYTES : SEC_BYTES;
  localparam int NW   = $clog2(MAXB + 1);

  logic [NW-1:0] cnt;
  logic [NW-1:0] target;
  akind_t        kind;
  logic [NW-1:0] row_sel;
  logic          to_col;
  logic          to_row;

  assign last    = take && ((cnt + NW'(1)) == target);
  assign to_col  = (kind == AK_PAGE) && (cnt < NW'(COL_BYTES));
  assign to_row  = ((kind == AK_PAGE) && (cnt >= NW'(COL_BYTES))) || (kind == AK_SECT);
  assign row_sel = (kind == AK_PAGE) ? (cnt - NW'(COL_BYTES)) : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      target <= '0;
      kind   <= AK_NONE;
    end else if (start) begin
      cnt  <= '0;
      kind <= kind_in;
      case (kind_in)
        AK_PAGE: target <= NW'(PG_BYTES);
        AK_SECT: target <= NW'(SEC_BYTES);
        AK_ZERO: target <= NW'(1);
        default: target <= '0;
      endcase
    end else if (take) begin
      cnt <= cnt + NW'(1);
    end
  end

  for (genvar i = 0; i < COL_BYTES; i++) begin : g_col
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst || start)                          q <= '0;
      else if (take && to_col && cnt == NW'(i))  q <= byte_in;
    end
    assign col[8*i +: 8] = q;
  end

  for (genvar j = 0; j < ROW_BYTES; j++) begin : g_row
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst || start)                              q <= '0;
      else if (take && to_row && row_sel == NW'(j))  q <= byte_in;
    end
    assign row[8*j +: 8] = q;
  end

endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
  parameter int DEPTH = 528,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int  PG_BYTES   = 2,
  parameter int  SEC_BYTES  = 3,
  parameter int  COL_BYTES  = 1,
  parameter int  PAGE_BYTES = 528,
  parameter bit  WIDE_BUS   = 1'b0,
  localparam int AW         = $clog2(PAGE_BYTES),
  localparam int CW         = $clog2(PAGE_BYTES + 2),
  localparam int ROW_BYTES  = ((PG_BYTES - COL_BYTES) > SEC_BYTES) ? (PG_BYTES - COL_BYTES) : SEC_BYTES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_stb,
  input  logic                   chip_en,
  input  logic                   cmd_latch,
  input  logic                   addr_latch,
  input  logic [7:0]             wr_byte,
  input  logic [AW-1:0]          rd_addr,
  output logic [7:0]             rd_data,
  output logic [1:0]             seq_state,
  output logic                   fail_flag,
  output logic                   op_start,
  output logic                   addr_done,
  output logic [8*COL_BYTES-1:0] col_addr,
  output logic [8*ROW_BYTES-1:0] row_addr,
  output logic [CW-1:0]          din_count
);

  localparam logic [CW-1:0] STEP = WIDE_BUS ? CW'(2) : CW'(1);

  sq_state_t st;
  sq_state_t after_q;
  logic      fail_q;
  logic      op_start_q;
  logic      addr_done_q;
  logic [CW-1:0] cnt;

  op_info_t info;
  logic is_reset, is_pconf, is_econf;
  logic valid, cmd_v, adr_v, dat_v;
  logic awaited, abort, launch, take, last, buf_we;

  nand_op_decode u_dec (
    .opc      (wr_byte),
    .info     (info),
    .is_reset (is_reset),
    .is_pconf (is_pconf),
    .is_econf (is_econf)
  );

  assign valid   = wr_stb && chip_en && !(cmd_latch && addr_latch);
  assign cmd_v   = valid && cmd_latch;
  assign adr_v   = valid && addr_latch;
  assign dat_v   = valid && !cmd_latch && !addr_latch;

  assign awaited = ((st == SQ_DATA) && is_pconf) || ((st == SQ_ECONF) && is_econf);
  assign abort   = cmd_v && !is_reset && (st != SQ_READY) && !awaited;
  assign launch  = cmd_v && !is_reset && info.starts && ((st == SQ_READY) || abort);
  assign take    = adr_v && (st == SQ_ADDR);
  assign buf_we  = dat_v && (st == SQ_DATA) && (cnt < CW'(PAGE_BYTES));

  nand_addr_collect #(
    .PG_BYTES  (PG_BYTES),
    .SEC_BYTES (SEC_BYTES),
    .COL_BYTES (COL_BYTES),
    .ROW_BYTES (ROW_BYTES)
  ) u_addr (
    .clk     (clk),
    .rst     (rst),
    .start   (launch),
    .kind_in (info.kind),
    .take    (take),
    .byte_in (wr_byte),
    .last    (last),
    .col     (col_addr),
    .row     (row_addr)
  );

  nand_page_buf #(
    .DEPTH (PAGE_BYTES),
    .AW    (AW)
  ) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (cnt[AW-1:0]),
    .wdata (wr_byte),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SQ_READY;
      after_q     <= SQ_READY;
      fail_q      <= 1'b0;
      op_start_q  <= 1'b0;
      addr_done_q <= 1'b0;
      cnt         <= '0;
    end else begin
      op_start_q  <= launch;
      addr_done_q <= take && last;
      if (cmd_v) begin
        if (is_reset) begin
          st     <= SQ_READY;
          fail_q <= 1'b0;
        end else begin
          if (abort) fail_q <= 1'b1;
          if (awaited) begin
            st <= SQ_READY;
          end else if (launch) begin
            st      <= (info.kind == AK_NONE) ? SQ_READY : SQ_ADDR;
            after_q <= info.after;
            if (info.clr_data) cnt <= '0;
          end else if (abort) begin
            st <= SQ_READY;
          end
        end
      end else if (adr_v) begin
        if (st == SQ_ADDR) begin
          if (last) st <= after_q;
        end else begin
          fail_q <= 1'b1;
          st     <= SQ_READY;
        end
      end else if (dat_v) begin
        if (st == SQ_DATA) begin
          if (buf_we) cnt <= cnt + STEP;
        end else begin
          fail_q <= 1'b1;
          st     <= SQ_READY;
        end
      end
    end
  end

  assign seq_state = st;
  assign fail_flag = fail_q;
  assign op_start  = op_start_q;
  assign addr_done = addr_done_q;
  assign din_count = cnt;

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int PAGE_BYTES = 528,
  parameter int CW         = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_stb,
  input logic          chip_en,
  input logic          cmd_latch,
  input logic          addr_latch,
  input logic [7:0]    wr_byte,
  input logic [1:0]    seq_state,
  input logic          fail_flag,
  input logic          addr_done,
  input logic [CW-1:0] din_count
);

  logic started;
  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
  end

  assert_deselect_R1: assert property (@(posedge clk) disable iff (rst)
    started && wr_stb && !chip_en |=>
      $stable(seq_state) && $stable(fail_flag) && $stable(din_count) && !addr_done);

  assert_both_latch_R2: assert property (@(posedge clk) disable iff (rst)
    started && wr_stb && chip_en && cmd_latch && addr_latch |=>
      $stable(seq_state) && $stable(fail_flag) && $stable(din_count) && !addr_done);

  assert_reset_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    wr_stb && chip_en && cmd_latch && !addr_latch && wr_byte == 8'hFF |=>
      seq_state == 2'd0 && !fail_flag);

  assert_stray_addr_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stb && chip_en && addr_latch && !cmd_latch && seq_state != 2'd1 |=>
      fail_flag && seq_state == 2'd0);

  assert_addr_done_src_R8: assert property (@(posedge clk) disable iff (rst)
    started && addr_done |->
      $past(wr_stb && chip_en && addr_latch && !cmd_latch) && $past(seq_state) == 2'd1);

  assert_stray_data_R10: assert property (@(posedge clk) disable iff (rst)
    wr_stb && chip_en && !addr_latch && !cmd_latch && seq_state != 2'd2 |=>
      fail_flag && seq_state == 2'd0);

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    din_count <= CW'(PAGE_BYTES));

  assert_full_drop_R11: assert property (@(posedge clk) disable iff (rst)
    wr_stb && chip_en && !addr_latch && !cmd_latch && seq_state == 2'd2 &&
      din_count >= CW'(PAGE_BYTES) |=>
      $stable(din_count) && seq_state == 2'd2 && $stable(fail_flag));

endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(
  .PAGE_BYTES (PAGE_BYTES),
  .CW         (CW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_stb     (wr_stb),
  .chip_en    (chip_en),
  .cmd_latch  (cmd_latch),
  .addr_latch (addr_latch),
  .wr_byte    (wr_byte),
  .seq_state  (seq_state),
  .fail_flag  (fail_flag),
  .addr_done  (addr_done),
  .din_count  (din_count)
);

// File: tb/test_nand_cmd_seq.sv
`timescale 1ns/1ps
module test_nand_cmd_seq;

  localparam int PB = 528;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0, chip_en = 1'b0, cmd_latch = 1'b0, addr_latch = 1'b0;
  logic [7:0]  wr_byte = 8'h00;
  logic [9:0]  rd_addr = '0;
  logic [7:0]  rd_data, rd_data_w;
  logic [1:0]  seq_state, seq_state_w;
  logic        fail_flag, op_start, addr_done;
  logic        fail_flag_w, op_start_w, addr_done_w;
  logic [7:0]  col_addr, col_addr_w;
  logic [23:0] row_addr, row_addr_w;
  logic [9:0]  din_count, din_count_w;

  always #2.5 clk = ~clk;

  nand_cmd_seq i_nand_cmd_seq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .chip_en(chip_en), .cmd_latch(cmd_latch),
    .addr_latch(addr_latch), .wr_byte(wr_byte), .rd_addr(rd_addr), .rd_data(rd_data),
    .seq_state(seq_state), .fail_flag(fail_flag), .op_start(op_start),
    .addr_done(addr_done), .col_addr(col_addr), .row_addr(row_addr), .din_count(din_count));

  nand_cmd_seq #(.WIDE_BUS(1'b1)) i_nand_cmd_seq_w (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .chip_en(chip_en), .cmd_latch(cmd_latch),
    .addr_latch(addr_latch), .wr_byte(wr_byte), .rd_addr(rd_addr), .rd_data(rd_data_w),
    .seq_state(seq_state_w), .fail_flag(fail_flag_w), .op_start(op_start_w),
    .addr_done(addr_done_w), .col_addr(col_addr_w), .row_addr(row_addr_w), .din_count(din_count_w));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model
  int m_state = 0, m_fail = 0, m_kind = 0, m_need = 0, m_got = 0, m_after = 0;
  int m_cnt = 0, m_wcnt = 0;
  logic [7:0]  m_col = 0;
  logic [23:0] m_row = 0;
  logic [7:0]  m_buf [PB];
  bit          m_ok  [PB];
  logic [7:0]  w_buf [PB];
  bit          w_ok  [PB];
  int e_op = 0, e_ad = 0;
  int cur_ra = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit in_table(input logic [7:0] b);
    return b == 8'h00 || b == 8'h80 || b == 8'h60 || b == 8'h70 || b == 8'h90;
  endfunction

  task automatic model(input logic s, ce, cl, al, input logic [7:0] b);
    e_op = 0; e_ad = 0;
    if (!(s && ce) || (cl && al)) return;
    if (cl) begin
      if (b == 8'hFF) begin m_state = 0; m_fail = 0; return; end
      if (m_state == 1 || (m_state == 2 && b != 8'h10) || (m_state == 3 && b != 8'hD0)) begin
        m_fail = 1; m_state = 0;
      end
      if (m_state == 2 || m_state == 3) m_state = 0;   // awaited confirm
      else if (in_table(b)) begin
        e_op = 1; m_col = 0; m_row = 0; m_got = 0;
        case (b)
          8'h00: begin m_kind = 1; m_need = 2; m_after = 0; end
          8'h80: begin m_kind = 1; m_need = 2; m_after = 2; m_cnt = 0; m_wcnt = 0; end
          8'h60: begin m_kind = 2; m_need = 3; m_after = 3; end
          8'h90: begin m_kind = 3; m_need = 1; m_after = 0; end
          default: begin m_kind = 0; m_need = 0; m_after = 0; end
        endcase
        m_state = (m_need > 0) ? 1 : 0;
      end
    end else if (al) begin
      if (m_state != 1) begin m_fail = 1; m_state = 0; return; end
      if (m_kind == 1 && m_got < 1) m_col = b;
      else if (m_kind == 1) m_row[8*(m_got-1) +: 8] = b;
      else if (m_kind == 2) m_row[8*m_got +: 8] = b;
      m_got++;
      if (m_got == m_need) begin m_state = m_after; e_ad = 1; end
    end else begin
      if (m_state != 2) begin m_fail = 1; m_state = 0; return; end
      if (m_cnt < PB) begin m_buf[m_cnt] = b; m_ok[m_cnt] = 1; m_cnt++; end
      if (m_wcnt < PB) begin w_buf[m_wcnt] = b; w_ok[m_wcnt] = 1; m_wcnt += 2; end
    end
  endtask

  task automatic drive(input logic s, ce, cl, al, input logic [7:0] b);
    logic [7:0] er, ew; bit eok, wok;
    wr_stb = s; chip_en = ce; cmd_latch = cl; addr_latch = al; wr_byte = b;
    rd_addr = 10'(cur_ra);
    er = m_buf[cur_ra]; eok = m_ok[cur_ra]; ew = w_buf[cur_ra]; wok = w_ok[cur_ra];
    model(s, ce, cl, al, b);
    @(negedge clk);
    chk(32'(seq_state), 32'(m_state), "R8 seq_state");
    chk(32'(fail_flag), 32'(m_fail),  "R4 fail_flag");
    chk(32'(op_start),  32'(e_op),    "R12 op_start");
    chk(32'(addr_done), 32'(e_ad),    "R8 addr_done");
    chk(32'(col_addr),  32'(m_col),   "R9 col_addr");
    chk(32'(row_addr),  32'(m_row),   "R9 row_addr");
    chk(32'(din_count), 32'(m_cnt),   "R11 din_count");
    chk(32'(din_count_w), 32'(m_wcnt), "R11 wide din_count");
    if (eok) chk(32'(rd_data),   32'(er), "R13 rd_data");
    if (wok) chk(32'(rd_data_w), 32'(ew), "R13 wide rd_data");
  endtask

  task automatic cmd(input logic [7:0] b); drive(1, 1, 1, 0, b); endtask
  task automatic adr(input logic [7:0] b); drive(1, 1, 0, 1, b); endtask
  task automatic dat(input logic [7:0] b); drive(1, 1, 0, 0, b); endtask
  task automatic idle();                   drive(0, 0, 0, 0, 8'h00); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < PB; i++) begin m_ok[i] = 0; w_ok[i] = 0; m_buf[i] = 0; w_buf[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();  // reset state
    chk(32'(seq_state), 0, "R3 reset state ready");

    // R6 read: two address bytes, column then row
    cmd(8'h00); adr(8'h12); chk(32'(seq_state), 1, "R6 read wants more");
    adr(8'h34); chk(32'(row_addr), 32'h34, "R9 row byte");
    // R6 ID: one byte; status: none
    cmd(8'h90); adr(8'h00); chk(32'(addr_done), 1, "R6 ID one byte");
    cmd(8'h70); chk(32'(seq_state), 0, "R6 status no address");
    // erase three bytes and confirm
    cmd(8'h60); adr(8'hA1); adr(8'hA2); chk(32'(seq_state), 1, "R6 erase wants 3");
    adr(8'hA3); chk(32'(seq_state), 3, "R8 erase confirm wait");
    chk(32'(row_addr), 32'hA3A2A1, "R9 erase row");
    cmd(8'hD0); chk(32'(fail_flag), 0, "R8 erase confirm pass");
    // program, short data and readback
    cmd(8'h80); adr(8'h05); adr(8'h06);
    dat(8'h11); dat(8'h22); dat(8'h33);
    chk(32'(din_count_w), 6, "R11 wide step two");
    for (int a = 0; a < 3; a++) begin cur_ra = a; idle(); idle(); end
    chk(32'(rd_data), 32'h33, "R13 buffer index 2");
    cur_ra = 0;
    cmd(8'h10); chk(32'(seq_state), 0, "R8 program confirm");
    // R5 unknown and confirms in ready
    cmd(8'h55); chk(32'(op_start), 0, "R5 unknown ignored");
    cmd(8'h10); cmd(8'hD0); chk(32'(fail_flag), 0, "R5 confirm in ready ignored");
    // R1 deselected, R2 both latches
    drive(1, 0, 1, 0, 8'h80); chk(32'(op_start), 0, "R1 deselected ignored");
    drive(1, 1, 1, 1, 8'h80); chk(32'(seq_state), 0, "R2 both latches ignored");
    // R7 stray address
    adr(8'h77); chk(32'(fail_flag), 1, "R7 stray address fails");
    cmd(8'hFF); chk(32'(fail_flag), 0, "R3 reset clears fail");
    // R4 command in address phase aborts then starts
    cmd(8'h00); adr(8'h01); cmd(8'h60);
    chk(32'(fail_flag), 1, "R4 abort fail"); chk(32'(seq_state), 1, "R4 new op accepted");
    adr(8'h0A); adr(8'h0B); adr(8'h0C); adr(8'h0D);
    chk(32'(seq_state), 0, "R7 extra address after count");
    // R4 unknown command in address phase
    cmd(8'hFF); cmd(8'h90); cmd(8'h42);
    chk(32'(seq_state), 0, "R4 unknown aborts to ready");
    // R11 overflow
    cmd(8'hFF); cmd(8'h80); adr(8'h00); adr(8'h01);
    for (int i = 0; i < PB + 2; i++) dat(8'(i ^ 8'h5A));
    chk(32'(din_count), PB, "R11 drop at full");
    chk(32'(fail_flag), 0, "R11 drop no fail");
    chk(32'(seq_state), 2, "R11 drop stays data-in");
    cur_ra = PB - 1; idle(); idle(); cur_ra = 0;
    cmd(8'h10);
    // R10 stray data
    dat(8'h99); chk(32'(fail_flag), 1, "R10 stray data fails");
    // R3 reset in mid-program
    cmd(8'h80); adr(8'h02); cmd(8'hFF);
    chk(32'(seq_state), 0, "R3 reset mid program");
    idle(); idle();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule